// File: doc/BRIEF.md
# Transmit Descriptor Ring Gatherer

This block drains frames from a circular list of 8-byte transmit descriptors held in shared memory and sends them out as a byte stream. Software fills descriptors and hands them over by setting the ownership bit. On a scan request the block checks the descriptor at its ring pointer and follows the chain up to the descriptor flagged as last segment. It streams the buffer bytes, then appends the padding bytes that the final descriptor asks for. It writes zero to each consumed status word and pulses a transmit event for every frame it finishes. A single scan sends at most 16 frames.

Each frame is handled in two walks of the chain. The first walk reads only status words. It confirms ownership along the whole chain and adds up the frame length. The second walk reads buffer addresses and data, streams the bytes and releases the descriptors. If a chain stops partway, the frame is therefore dropped before any byte leaves the block. A mode input selects how segment lengths are coded and how the ring pointer wraps.

Descriptor word 0 is the status word and word 1 is the byte address of the buffer. Memory is 32-bit and little-endian: byte address `a` is lane `a[1:0]` of the word at `a` with its low two bits cleared. The output stream is valid/ready. Once `out_valid` is high, `out_data` and `out_last` hold until `out_ready` takes the beat. The memory master keeps `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_gnt`. Read data comes back later on a `mem_rvalid` cycle, and only one access is outstanding at a time.

Top module: `tx_ring_gatherer`

## Requirements
- R1: While reset is asserted and right after it, `mem_req`, `out_valid`, `tx_event` and `scan_done` are low.
- R2: A scan started with `chan_en` low, or with a non-owned descriptor (status bit 31 clear) at the ring pointer, ends with `scan_done` and produces no bytes, no memory writes and no event. The ring pointer stays where it was.
- R3: In mode 0 a segment carries status bits 11:0 bytes, read from the buffer address upward. A zero-length segment reads no data but still moves the walk to the next descriptor.
- R4: In mode 1 a segment carries 4 times bits 11:0 bytes. When bit 20 is set, the 2-bit value in bits 25:24 is subtracted from that count, and a result below zero counts as zero.
- R5: With p taken from bits 23:22 of the last-segment descriptor, (p−1) mod 4 zero bytes follow the data of the frame.
- R6: A frame takes in every descriptor from the ring pointer through the first one with bit 29 (last segment) set. `out_last` is high on the frame's final byte and on no other byte.
- R7: If a descriptor after the first one in a chain is not owned, the frame is dropped. No byte is sent, nothing is written, no event fires and the scan ends. A later scan starts again from the same descriptor.
- R8: Each descriptor in a frame without bit 30 (first segment) has its status word written to zero during the walk. The descriptor at the ring pointer is zeroed after the frame's last byte. Then `tx_event` pulses for one cycle.
- R9: Mode 0 wrap: the pointer moves up by 8, and if the result equals `ring_end` it becomes `ring_start`.
- R10: Mode 1 wrap: if the pointer equals `ring_end` it becomes `ring_start`, otherwise it moves up by 8.
- R11: One scan sends at most 16 frames. It stops early at a non-owned descriptor, and `scan_done` pulses when it ends.
- R12: A frame is cut to 2048 bytes. Descriptors past the cut are still walked and released.
- R13: The stream holds `out_data`/`out_last` while `out_valid` is high and `out_ready` is low. The memory request holds address and type until `mem_gnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 1 | Length coding and wrap rule select (0 or 1) |
| chan_en | input | 1 | Channel enable, sampled at scan start |
| ring_start | input | ADDR_W | First descriptor address of the ring |
| ring_end | input | ADDR_W | Ring end address used by the wrap rule |
| ring_load | input | 1 | Copies `ring_start` into the ring pointer while idle |
| scan_start | input | 1 | Starts one scan pass while idle |
| scan_done | output | 1 | One-cycle pulse at the end of a scan pass |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data (always zero: release) |
| mem_gnt | input | 1 | Access accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream sink ready |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of the frame |
| tx_event | output | 1 | One-cycle pulse per completed frame |

## Verification
The bench builds its descriptor rings in a memory model and fills buffers with a byte pattern derived from the address. Each frame's expected byte string is computed from the length coding. Several shapes are used: single and multi-segment chains, a zero-length middle segment, mode 1 words with and without the subtract field, every pad code, a segment that underflows, and an oversize frame. Separate cases exercise unaligned buffers, a non-owned first or middle descriptor, and a disabled channel. Ring wrap is told apart by placing an owned decoy in the slot the wrong rule would pick next. A 20-frame ring shows the cap of 16 frames per scan. A random-stall pass on both the stream and the memory grant shows that the byte sequence does not depend on back-pressure.

// File: rtl/txg_pkg.sv
package txg_pkg;
  // descriptor geometry
  localparam int DESC_BYTES = 8;
  localparam int WORD_BYTES = 4;

  // status word layout
  localparam int OWN_BIT    = 31;
  localparam int FS_BIT     = 30;
  localparam int LS_BIT     = 29;
  localparam int SUB_HI     = 25;
  localparam int SUB_LO     = 24;
  localparam int PAD_HI     = 23;
  localparam int PAD_LO     = 22;
  localparam int SUB_EN_BIT = 20;
  localparam int LEN_BITS   = 12;

  typedef enum logic [4:0] {
    S_IDLE, S_P1_RD, S_P1_WT, S_P1_EV,
    S_P2_ST, S_P2_STW, S_P2_AD, S_P2_ADW,
    S_P2_DAT, S_P2_RD, S_P2_DW, S_P2_OUT,
    S_P2_REL, S_P2_NX, S_PAD, S_FREL, S_DONE
  } txg_state_e;
endpackage

// File: rtl/txg_desc_decode.sv
module txg_desc_decode
  import txg_pkg::*;
#(
  parameter int SEG_W = LEN_BITS + 2
) (
  input  logic             mode,
  input  logic [31:0]      status,
  output logic             own,
  output logic             first,
  output logic             last,
  output logic [SEG_W-1:0] seg_len,
  output logic [1:0]       pad_bytes
);
  logic [SEG_W-1:0] raw, words, cut;

  always_comb begin
    own   = status[OWN_BIT];
    first = status[FS_BIT];
    last  = status[LS_BIT];
    raw   = SEG_W'(status[LEN_BITS-1:0]);
    words = raw << 2;
    cut   = status[SUB_EN_BIT] ? SEG_W'(status[SUB_HI:SUB_LO]) : '0;
    if (mode) seg_len = (words >= cut) ? (words - cut) : '0;
    else      seg_len = raw;
    // (p - 1) mod 4 through 2-bit wrap
    pad_bytes = status[PAD_HI:PAD_LO] - 2'd1;
  end
endmodule

// File: rtl/txg_ring_step.sv
module txg_ring_step #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 8
) (
  input  logic              mode,
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] ring_start,
  input  logic [ADDR_W-1:0] ring_end,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] inc;
  assign inc = cur + ADDR_W'(STEP);

  always_comb begin
    if (mode) nxt = (cur == ring_end) ? ring_start : inc;   // compare, then step
    else      nxt = (inc == ring_end) ? ring_start : inc;   // step, then compare
  end
endmodule

// File: rtl/tx_ring_gatherer.sv
module tx_ring_gatherer
  import txg_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_FRAME = 2048,
  parameter int PASS_MAX  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode,
  input  logic              chan_en,
  input  logic [ADDR_W-1:0] ring_start,
  input  logic [ADDR_W-1:0] ring_end,
  input  logic              ring_load,
  input  logic              scan_start,
  output logic              scan_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              tx_event
);
  localparam int SEG_W = LEN_BITS + 2;
  localparam int TOT_W = $clog2(MAX_FRAME + 1);
  localparam int FC_W  = $clog2(PASS_MAX + 1);
  localparam int SUM_W = ((TOT_W > SEG_W) ? TOT_W : SEG_W) + 2;

  txg_state_e        state;
  logic [ADDR_W-1:0] cur, walk, walk_nxt, buf_q, byte_addr;
  logic [31:0]       st_q;
  logic [SEG_W-1:0]  boff, segrem;
  logic [TOT_W-1:0]  total, sent, tot_next;
  logic [FC_W-1:0]   frames;
  logic [7:0]        byte_q;
  logic [SUM_W-1:0]  sum_w;

  logic             d_own, d_first, d_last;
  logic [SEG_W-1:0] d_seg;
  logic [1:0]       d_pad;

  txg_desc_decode #(.SEG_W(SEG_W)) u_dec (
    .mode(mode), .status(st_q), .own(d_own), .first(d_first), .last(d_last),
    .seg_len(d_seg), .pad_bytes(d_pad)
  );

  txg_ring_step #(.ADDR_W(ADDR_W), .STEP(DESC_BYTES)) u_step (
    .mode(mode), .cur(walk), .ring_start(ring_start), .ring_end(ring_end),
    .nxt(walk_nxt)
  );

  assign byte_addr = buf_q + ADDR_W'(boff);

  always_comb begin
    sum_w    = SUM_W'(total) + SUM_W'(d_seg) + (d_last ? SUM_W'(d_pad) : SUM_W'(0));
    tot_next = (sum_w > SUM_W'(MAX_FRAME)) ? TOT_W'(MAX_FRAME) : TOT_W'(sum_w);
  end

  // memory master
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      S_P1_RD, S_P2_ST: begin mem_req = 1'b1; mem_addr = walk; end
      S_P2_AD:  begin mem_req = 1'b1; mem_addr = walk + ADDR_W'(WORD_BYTES); end
      S_P2_RD:  begin mem_req = 1'b1; mem_addr = {byte_addr[ADDR_W-1:2], 2'b00}; end
      S_P2_REL: begin mem_req = !d_first; mem_we = 1'b1; mem_addr = walk; end
      S_FREL:   begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = cur; end
      default: ;
    endcase
  end

  // byte stream
  always_comb begin
    out_valid = (state == S_P2_OUT) || ((state == S_PAD) && (sent < total));
    out_data  = (state == S_P2_OUT) ? byte_q : 8'h00;
    out_last  = out_valid && ((sent + TOT_W'(1)) == total);
  end

  assign scan_done = (state == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;  cur <= '0;  walk <= '0;  buf_q <= '0;  st_q <= '0;
      boff <= '0;  segrem <= '0;  total <= '0;  sent <= '0;  frames <= '0;
      byte_q <= '0;  tx_event <= 1'b0;
    end else begin
      tx_event <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (ring_load) cur <= ring_start;
          if (scan_start) begin
            frames <= '0;
            walk   <= cur;
            total  <= '0;
            state  <= chan_en ? S_P1_RD : S_DONE;
          end
        end
        // first walk: ownership and length only
        S_P1_RD: if (mem_gnt) state <= S_P1_WT;
        S_P1_WT: if (mem_rvalid) begin st_q <= mem_rdata; state <= S_P1_EV; end
        S_P1_EV: begin
          if (!d_own) state <= S_DONE;
          else begin
            total <= tot_next;
            if (d_last) begin walk <= cur; sent <= '0; state <= S_P2_ST; end
            else begin walk <= walk_nxt; state <= S_P1_RD; end
          end
        end
        // second walk: stream and release
        S_P2_ST:  if (mem_gnt) state <= S_P2_STW;
        S_P2_STW: if (mem_rvalid) begin st_q <= mem_rdata; state <= S_P2_AD; end
        S_P2_AD:  if (mem_gnt) state <= S_P2_ADW;
        S_P2_ADW: if (mem_rvalid) begin
          buf_q  <= mem_rdata[ADDR_W-1:0];
          boff   <= '0;
          segrem <= d_seg;
          state  <= S_P2_DAT;
        end
        S_P2_DAT: state <= ((segrem == '0) || (sent >= total)) ? S_P2_REL : S_P2_RD;
        S_P2_RD:  if (mem_gnt) state <= S_P2_DW;
        S_P2_DW:  if (mem_rvalid) begin
          byte_q <= mem_rdata[{byte_addr[1:0], 3'b000} +: 8];
          state  <= S_P2_OUT;
        end
        S_P2_OUT: if (out_ready) begin
          sent   <= sent + TOT_W'(1);
          boff   <= boff + SEG_W'(1);
          segrem <= segrem - SEG_W'(1);
          state  <= S_P2_DAT;
        end
        S_P2_REL: if (d_first || mem_gnt) state <= S_P2_NX;
        S_P2_NX: begin
          walk  <= walk_nxt;
          state <= d_last ? S_PAD : S_P2_ST;
        end
        S_PAD: begin
          if (sent >= total) state <= S_FREL;
          else if (out_ready) sent <= sent + TOT_W'(1);
        end
        S_FREL: if (mem_gnt) begin
          cur      <= walk;
          tx_event <= 1'b1;
          frames   <= frames + FC_W'(1);
          total    <= '0;
          state    <= (frames == FC_W'(PASS_MAX - 1)) ? S_DONE : S_P1_RD;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // assertions
  assert_out_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  assert_mem_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_disabled_scan_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) && scan_start && !chan_en |=> scan_done && !tx_event);

  assert_pass_limit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_event |-> (frames != '0) && (frames <= FC_W'(PASS_MAX)));

  assert_event_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_event |=> !tx_event);

  assert_frame_cap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (sent < total) && (total <= TOT_W'(MAX_FRAME)));
endmodule

// File: tb/tx_ring_gatherer_test.sv
module tx_ring_gatherer_test;
  localparam int AW = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic          rst_n = 1'b0;
  logic          mode = 1'b0, chan_en = 1'b1;
  logic [AW-1:0] ring_start = '0, ring_end = '0;
  logic          ring_load = 1'b0, scan_start = 1'b0;
  logic          scan_done, mem_req, mem_we, out_valid, out_last, tx_event;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [7:0]    out_data;
  logic          mem_gnt = 1'b0, mem_rvalid = 1'b0, out_ready = 1'b0;
  logic [31:0]   mem_rdata = '0;

  tx_ring_gatherer uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .chan_en(chan_en),
    .ring_start(ring_start), .ring_end(ring_end), .ring_load(ring_load),
    .scan_start(scan_start), .scan_done(scan_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .tx_event(tx_event)
  );

  logic [31:0] mem [0:1023];
  logic [31:0] rd_pend = '0;
  bit          pend = 1'b0, bp = 1'b0;
  int          checks = 0, fails = 0, evs = 0, wrs = 0, dones = 0;
  int unsigned cyc = 0;
  logic [7:0]  got_q[$], exp_q[$], frm_q[$];
  bit          gl_q[$], el_q[$];

  function automatic logic [7:0] pat(int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  // sink and memory model, driven away from the active edge
  always @(negedge clk) begin : bus_model
    bit r, g;
    r = bp ? 1'($urandom % 2) : 1'b1;
    out_ready = r;
    if (rst_n && out_valid && r) begin
      got_q.push_back(out_data);
      gl_q.push_back(out_last);
    end
    mem_rvalid = pend;
    mem_rdata  = rd_pend;
    pend       = 1'b0;
    g = rst_n && mem_req && (bp ? ($urandom % 3 != 0) : 1'b1);
    mem_gnt = g;
    if (g) begin
      if (mem_we) begin mem[mem_addr[11:2]] = mem_wdata; wrs++; end
      else begin rd_pend = mem[mem_addr[11:2]]; pend = 1'b1; end
    end
    if (rst_n && tx_event) evs++;
    if (rst_n && scan_done) dones++;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic end_frame();
    while (frm_q.size() > 2048) void'(frm_q.pop_back());
    for (int i = 0; i < frm_q.size(); i++) begin
      exp_q.push_back(frm_q[i]);
      el_q.push_back(i == frm_q.size() - 1);
    end
    frm_q.delete();
  endtask

  // write a descriptor; when add is set, append its expected bytes
  task automatic desc(int a, bit own, bit fs, bit ls, int len, bit se, int sub,
                      int p, int b, bit add);
    logic [31:0] w;
    int n;
    w = '0;
    w[31] = own; w[30] = fs; w[29] = ls; w[25:24] = 2'(sub);
    w[23:22] = 2'(p); w[20] = se; w[11:0] = 12'(len);
    mem[a >> 2] = w;
    mem[(a >> 2) + 1] = 32'(b);
    if (add) begin
      if (mode) begin
        n = len * 4 - (se ? sub : 0);
        if (n < 0) n = 0;
      end else n = len;
      for (int i = 0; i < n; i++) frm_q.push_back(pat(b + i));
      if (ls) begin
        for (int i = 0; i < ((p + 3) % 4); i++) frm_q.push_back(8'h00);
        end_frame();
      end
    end
  endtask

  task automatic clear_ring();
    for (int a = 'h100; a < 'h200; a += 4) mem[a >> 2] = '0;
  endtask

  task automatic load(int s, int e);
    @(negedge clk);
    ring_start = AW'(s); ring_end = AW'(e); ring_load = 1'b1;
    @(negedge clk);
    ring_load = 1'b0;
  endtask

  task automatic scan();
    int d0;
    d0 = dones;
    @(negedge clk); scan_start = 1'b1;
    @(negedge clk); scan_start = 1'b0;
    while (dones == d0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic compare(string req);
    int bad;
    check(got_q.size() == exp_q.size(), req, "stream length", got_q.size(), exp_q.size());
    bad = -1;
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
      if (bad < 0 && (got_q[i] != exp_q[i] || gl_q[i] != el_q[i])) bad = i;
    if (bad >= 0)
      check(1'b0, req, $sformatf("byte+last at index %0d", bad),
            int'({gl_q[bad], got_q[bad]}), int'({el_q[bad], exp_q[bad]}));
    else check(1'b1, req, "bytes", 0, 0);
    got_q.delete(); gl_q.delete(); exp_q.delete(); el_q.delete();
  endtask

  initial begin : stimulus
    int e0, w0;
    for (int i = 0; i < 1024; i++)
      mem[i] = {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
    clear_ring();
    repeat (4) @(negedge clk);
    // R1: reset state
    check(!mem_req && !out_valid && !tx_event && !scan_done, "R1", "outputs in reset",
          int'({mem_req, out_valid, tx_event, scan_done}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!mem_req && !out_valid && !tx_event && !scan_done, "R1", "outputs after reset",
          int'({mem_req, out_valid, tx_event, scan_done}), 0);

    // R3: mode 0 single segment, unaligned buffer
    mode = 1'b0; chan_en = 1'b1;
    load('h100, 'h120);
    desc('h100, 1, 1, 1, 5, 0, 0, 1, 'h401, 1);
    e0 = evs;
    scan();
    compare("R3");
    check(evs - e0 == 1, "R8", "events", evs - e0, 1);
    check(mem['h100 >> 2] == 0, "R8", "first status cleared", int'(mem['h100 >> 2]), 0);

    // R6 R5 R3 R8: three segments, zero-length middle, pad code 0 -> 3 bytes
    desc('h108, 1, 1, 0, 3, 0, 0, 0, 'h502, 1);
    desc('h110, 1, 0, 0, 0, 0, 0, 0, 'h540, 1);
    desc('h118, 1, 0, 1, 4, 0, 0, 0, 'h603, 1);
    w0 = wrs; e0 = evs;
    scan();
    compare("R6");
    check(wrs - w0 == 3, "R8", "release writes", wrs - w0, 3);
    check((mem['h108>>2] | mem['h110>>2] | mem['h118>>2]) == 0, "R8", "statuses zeroed",
          int'(mem['h108>>2] | mem['h110>>2] | mem['h118>>2]), 0);
    check(evs - e0 == 1, "R8", "events", evs - e0, 1);

    // R9: mode 0 wrap from 0x118 skips 0x120 (decoy) to 0x100
    desc('h120, 1, 1, 1, 6, 0, 0, 1, 'h780, 0);
    desc('h100, 1, 1, 1, 2, 0, 0, 1, 'h700, 1);
    scan();
    compare("R9");

    // R4: mode 1 words with subtract, pad code 3 -> 2 bytes
    clear_ring(); mode = 1'b1;
    load('h100, 'h110);
    desc('h100, 1, 1, 0, 2, 1, 3, 0, 'h800, 1);
    desc('h108, 1, 0, 1, 1, 0, 0, 3, 'h901, 1);
    scan();
    compare("R4");

    // R10: mode 1 wraps at 0x110 to 0x100, not to decoy at 0x118
    desc('h110, 1, 1, 1, 1, 0, 0, 1, 'hA00, 1);
    desc('h118, 1, 1, 1, 1, 0, 0, 1, 'hA80, 0);
    desc('h100, 1, 1, 1, 1, 0, 0, 1, 'hA40, 1);
    e0 = evs;
    scan();
    compare("R10");
    check(evs - e0 == 2, "R10", "events", evs - e0, 2);

    // R7: non-owned second descriptor drops the frame
    clear_ring(); mode = 1'b0;
    load('h100, 'h140);
    desc('h100, 1, 1, 0, 3, 0, 0, 0, 'hB00, 0);
    desc('h108, 0, 0, 1, 2, 0, 0, 1, 'hB40, 0);
    w0 = wrs; e0 = evs;
    scan();
    compare("R7");
    check(wrs == w0 && evs == e0, "R7", "writes+events", (wrs - w0) + (evs - e0), 0);
    desc('h100, 1, 1, 0, 3, 0, 0, 0, 'hB00, 1);
    desc('h108, 1, 0, 1, 2, 0, 0, 1, 'hB40, 1);
    scan();
    compare("R7");

    // R2: non-owned first descriptor, then disabled channel
    w0 = wrs; e0 = evs;
    scan();
    compare("R2");
    check(wrs == w0 && evs == e0, "R2", "writes+events (not owned)", (wrs - w0) + (evs - e0), 0);
    chan_en = 1'b0;
    desc('h110, 1, 1, 1, 3, 0, 0, 1, 'hC00, 0);
    scan();
    compare("R2");
    check(wrs == w0 && evs == e0, "R2", "writes+events (disabled)", (wrs - w0) + (evs - e0), 0);
    chan_en = 1'b1;
    desc('h110, 1, 1, 1, 3, 0, 0, 1, 'hC00, 1);
    scan();
    compare("R2");

    // R11: 20 ready frames, 16 per pass
    clear_ring();
    load('h100, 'h1A0);
    for (int i = 0; i < 20; i++)
      desc('h100 + 8*i, 1, 1, 1, (i % 3) + 1, 0, 0, 1, 'h400 + 16*i, i < 16);
    e0 = evs;
    scan();
    compare("R11");
    check(evs - e0 == 16, "R11", "frames in first pass", evs - e0, 16);
    for (int i = 16; i < 20; i++)
      desc('h100 + 8*i, 1, 1, 1, (i % 3) + 1, 0, 0, 1, 'h400 + 16*i, 1);
    e0 = evs;
    scan();
    compare("R11");
    check(evs - e0 == 4, "R11", "frames in second pass", evs - e0, 4);

    // R12: oversize frame cut at 2048
    clear_ring();
    load('h100, 'h140);
    desc('h100, 1, 1, 1, 2100, 0, 0, 2, 'h400, 1);
    scan();
    compare("R12");

    // R13 with R4 clamp: random stalls on stream and memory
    bp = 1'b1; mode = 1'b1;
    clear_ring();
    load('h100, 'h140);
    desc('h100, 1, 1, 0, 3, 1, 1, 0, 'h501, 1);
    desc('h108, 1, 0, 0, 0, 1, 2, 0, 'h600, 1);
    desc('h110, 1, 0, 1, 2, 0, 0, 0, 'h703, 1);
    e0 = evs;
    scan();
    compare("R13");
    check(evs - e0 == 1, "R13", "events under stalls", evs - e0, 1);
    bp = 1'b0;

    summary();
    $finish;
  end
endmodule